// File: doc/BRIEF.md
# Prescaled Compare-Match Event Timer

A single-channel timer that serves as a programmable tick or one-shot event source. A 16-bit counter advances on prescaled pulses of a slow reference strobe. The strobe is a one-cycle enable in the system clock domain, nominally at 32.768 kHz. A 4-bit scale field picks a divisor of 2^scale, and any scale above 8 saturates to 256. Two 16-bit compare registers watch the counter.

Matching the second comparator sets a sticky status flag. On the following prescaled tick the counter folds back to zero, so periodic operation needs only a flag acknowledge. Matching the first comparator sets its own flag and leaves the count running. The interrupt is a level output. Each comparator contributes to it only while its two-bit event-mode field holds 3.

Software reaches four 16-bit registers through a simple write port and a combinational read mux. The address selects setup (0), counter (1), compare 1 (2) or compare 2 (3). Setup layout: bit 15 run, bit 14 compare-2 flag, bit 13 compare-1 flag, bits 9:8 compare-2 mode, bits 7:6 compare-1 mode, bits 3:0 scale. The flags are write-one-to-clear, so one setup write can both stop the counter and acknowledge both events.

Top module: `evtimer`

## Requirements
- R1: After reset all four registers read zero and irq is low.
- R2: While running, the counter increments once every 2^scale reference pulses; scale values 9 to 15 behave as 8 (divisor 256).
- R3: The counter does not move while run (setup bit 15) is 0. The prescaler phase clears while stopped and on every counter write, so the first increment comes on the 2^scale-th pulse afterwards.
- R4: A write to address 1 loads the counter with the written value and takes precedence over a tick in the same cycle.
- R5: When a tick brings the counter equal to compare 2, setup bit 14 sets. The next tick takes the counter to zero instead of incrementing.
- R6: When a tick brings the counter equal to compare 1, setup bit 13 sets and counting continues normally.
- R7: irq is high exactly while (bit 14 set and bits 9:8 equal 3) or (bit 13 set and bits 7:6 equal 3), and it holds until the flag is cleared.
- R8: A setup write clears each flag whose written bit (14 or 13) is 1 and leaves a flag alone where the written bit is 0. The same write loads run, both modes and scale.
- R9: If a compare-2 match and a clearing setup write fall in the same cycle, the flag ends up set.
- R10: Setup reads return zero in bits 12:10 and 5:4. The compare registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle reference strobe (32.768 kHz rate) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 setup, 1 counter, 2 compare 1, 3 compare 2 |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can land in one cycle: a compare match setting a status flag, and a setup write acknowledging that flag. A counter write can also coincide with a prescaled tick. The bench provokes the first collision directly: it parks the counter one below compare 2 with a divisor of 1, then issues the clearing write in the same cycle as a reference pulse. It expects the flag and irq to survive. Random traffic with small compare values and frequent writes produces both collisions often, and every cycle is judged against a bench model that gives the match priority over the clear and the load priority over the tick.

// File: rtl/evtimer.sv
`timescale 1ns/1ps
module evtimer #(
  parameter int CW        = 16,
  parameter int MAX_SCALE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  localparam int PW      = (MAX_SCALE < 1) ? 1 : MAX_SCALE;
  localparam int B_RUN   = 15;
  localparam int B_F2    = 14;
  localparam int B_F1    = 13;
  localparam int B_M2    = 8;
  localparam int B_M1    = 6;
  localparam logic [1:0] MODE_IRQ = 2'b11;

  logic          run_q, f2_q, f1_q;
  logic [1:0]    m2_q, m1_q;
  logic [3:0]    scale_q;
  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q, cmp1_q, cmp2_q;

  wire setup_wr = wr_en && (addr == 2'd0);
  wire cnt_wr   = wr_en && (addr == 2'd1);

  wire [3:0]    eff_scale = (scale_q > 4'(MAX_SCALE)) ? 4'(MAX_SCALE) : scale_q;
  wire [PW:0]   div       = (PW+1)'(1) << eff_scale;
  wire [PW-1:0] pre_last  = PW'(div - (PW+1)'(1));

  wire          tick   = run_q && ref_tick && (pre_q >= pre_last);
  wire [CW-1:0] cnt_nx = (cnt_q == cmp2_q) ? '0 : cnt_q + 1'b1;
  wire          hit2   = tick && !cnt_wr && (cnt_nx == cmp2_q);
  wire          hit1   = tick && !cnt_wr && (cnt_nx == cmp1_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (!run_q || cnt_wr) pre_q <= '0;
    else if (ref_tick) pre_q <= tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_wr) cnt_q <= wdata;
    else if (tick) cnt_q <= cnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp1_q <= '0;
      cmp2_q <= '0;
    end else if (wr_en) begin
      if (addr == 2'd2) cmp1_q <= wdata;
      if (addr == 2'd3) cmp2_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      m2_q    <= '0;
      m1_q    <= '0;
      scale_q <= '0;
    end else if (setup_wr) begin
      run_q   <= wdata[B_RUN];
      m2_q    <= wdata[B_M2+1:B_M2];
      m1_q    <= wdata[B_M1+1:B_M1];
      scale_q <= wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f2_q <= 1'b0;
      f1_q <= 1'b0;
    end else begin
      f2_q <= hit2 | (f2_q & ~(setup_wr & wdata[B_F2]));
      f1_q <= hit1 | (f1_q & ~(setup_wr & wdata[B_F1]));
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: begin
        rdata[B_RUN]         = run_q;
        rdata[B_F2]          = f2_q;
        rdata[B_F1]          = f1_q;
        rdata[B_M2+1:B_M2]   = m2_q;
        rdata[B_M1+1:B_M1]   = m1_q;
        rdata[3:0]           = scale_q;
      end
      2'd1: rdata = cnt_q;
      2'd2: rdata = cmp1_q;
      default: rdata = cmp2_q;
    endcase
  end

  assign irq = (f2_q && (m2_q == MODE_IRQ)) || (f1_q && (m1_q == MODE_IRQ));
endmodule

// File: rtl/evtimer_chk.sv
`timescale 1ns/1ps
module evtimer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic [CW-1:0] wdata,
  input logic          ref_tick,
  input logic          run,
  input logic          tick,
  input logic          f1,
  input logic          f2,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp2,
  input logic          irq
);
  wire cnt_wr = wr_en && (addr == 2'd1);
  wire clr2   = wr_en && (addr == 2'd0) && wdata[14];

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> (cnt == $past(cnt))); // R3

  AST_NO_MOVE_WITHOUT_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_tick && !cnt_wr) |=> $stable(cnt)); // R2

  AST_WRAP_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && (cnt == cmp2)) |=> (cnt == '0)); // R5

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata))); // R4

  AST_FLAG2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (f2 && !clr2) |=> f2); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (f1 || f2)); // R7
endmodule

bind evtimer evtimer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ref_tick(ref_tick), .run(run_q), .tick(tick), .f1(f1_q), .f2(f2_q),
  .cnt(cnt_q), .cmp2(cmp2_q), .irq(irq)
);

// File: tb/evtimer_test.sv
`timescale 1ns/1ps
module evtimer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evtimer uut (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
               .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  logic m_run, m_f2, m_f1;
  logic [1:0] m_m2, m_m1;
  logic [3:0] m_sc;
  int unsigned m_pre;
  logic [15:0] m_cnt, m_c1, m_c2;

  function automatic int unsigned divisor(input logic [3:0] s);
    return (s > 4'd8) ? 256 : (1 << s);
  endfunction

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {m_run, m_f2, m_f1, 3'b000, m_m2, m_m1, 2'b00, m_sc};
      2'd1: return m_cnt;
      2'd2: return m_c1;
      default: return m_c2;
    endcase
  endfunction

  function automatic logic m_irq();
    return (m_f2 && m_m2 == 2'b11) || (m_f1 && m_m1 == 2'b11);
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_f2 = 0; m_f1 = 0; m_m2 = 0; m_m1 = 0; m_sc = 0;
    m_pre = 0; m_cnt = 0; m_c1 = 0; m_c2 = 0;
  endtask

  task automatic cyc(input bit r, input bit w, input logic [1:0] a, input logic [15:0] d);
    bit sw, cw, tk, h1, h2;
    logic [15:0] nx, ncnt;
    int unsigned npre;
    ref_tick = r; wr_en = w; addr = a; wdata = d;
    sw = w && a == 2'd0;
    cw = w && a == 2'd1;
    tk = m_run && r && (m_pre >= divisor(m_sc) - 1);
    nx = (m_cnt == m_c2) ? 16'h0 : m_cnt + 16'h1;
    h2 = tk && !cw && nx == m_c2;
    h1 = tk && !cw && nx == m_c1;
    npre = (!m_run || cw) ? 0 : (r ? (tk ? 0 : m_pre + 1) : m_pre);
    ncnt = cw ? d : (tk ? nx : m_cnt);
    @(posedge clk);
    m_pre = npre;
    m_cnt = ncnt;
    m_f2 = h2 | (m_f2 & ~(sw & d[14]));
    m_f1 = h1 | (m_f1 & ~(sw & d[13]));
    if (sw) begin m_run = d[15]; m_m2 = d[9:8]; m_m1 = d[7:6]; m_sc = d[3:0]; end
    if (w && a == 2'd2) m_c1 = d;
    if (w && a == 2'd3) m_c2 = d;
    @(negedge clk);
    check("R7 irq vs model", {15'b0, irq}, {15'b0, m_irq()});
    case (a)
      2'd0: check("R8 setup vs model", rdata, m_read(a));
      2'd1: check("R2 counter vs model", rdata, m_read(a));
      default: check("R10 compare vs model", rdata, m_read(a));
    endcase
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    ref_tick = 0; wr_en = 0; addr = a;
    #1 v = rdata;
  endtask

  logic [15:0] v;

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v); check("R1 reset register", v, 16'h0);
    end
    check("R1 reset irq", {15'b0, irq}, 16'h0);

    cyc(0, 1, 3, 16'd3);
    cyc(0, 1, 0, 16'h8301);
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0);
    peek(1, v); check("R2 count after 4 pulses div2", v, 16'd2);
    cyc(1, 0, 1, 0); cyc(1, 0, 1, 0);
    peek(1, v); check("R5 counter reaches compare2", v, 16'd3);
    check("R5 irq on match", {15'b0, irq}, 16'h1);
    cyc(1, 0, 1, 0); cyc(1, 0, 1, 0);
    peek(1, v); check("R5 wrap to zero", v, 16'd0);
    check("R7 irq held until cleared", {15'b0, irq}, 16'h1);

    cyc(0, 1, 0, 16'h6000);
    check("R8 clear and stop drops irq", {15'b0, irq}, 16'h0);
    peek(0, v); check("R8 setup after clear", v, 16'h0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0);
    peek(1, v); check("R3 stopped counter holds", v, 16'd0);

    cyc(0, 1, 1, 16'h1234);
    peek(1, v); check("R4 counter load", v, 16'h1234);

    cyc(0, 1, 0, 16'h8002);
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0);
    peek(1, v); check("R3 no step before full period", v, 16'h1234);
    cyc(1, 0, 1, 0);
    peek(1, v); check("R3 first step on 4th pulse", v, 16'h1235);

    cyc(0, 1, 0, 16'h800C);
    cyc(0, 1, 1, 16'h0);
    for (int i = 0; i < 255; i++) cyc(1, 0, 1, 0);
    peek(1, v); check("R2 saturated scale 255 pulses", v, 16'd0);
    cyc(1, 0, 1, 0);
    peek(1, v); check("R2 saturated scale 256th pulse", v, 16'd1);

    cyc(0, 1, 2, 16'd5);
    cyc(0, 1, 3, 16'hFFFF);
    cyc(0, 1, 0, 16'h80C0);
    cyc(0, 1, 1, 16'd4);
    cyc(1, 0, 1, 0);
    peek(1, v); check("R6 counter at compare1", v, 16'd5);
    check("R6 irq from compare1", {15'b0, irq}, 16'h1);
    peek(0, v); check("R6 flag bit13", v, 16'hA0C0);
    cyc(1, 0, 1, 0);
    peek(1, v); check("R6 counting continues", v, 16'd6);

    cyc(0, 1, 0, 16'h6000);
    cyc(0, 1, 3, 16'd10);
    cyc(0, 1, 1, 16'd9);
    cyc(0, 1, 0, 16'h8300);
    cyc(1, 1, 0, 16'hC300);
    check("R9 match beats clear irq", {15'b0, irq}, 16'h1);
    peek(0, v); check("R9 flag kept", v, 16'hC300);

    cyc(0, 1, 0, 16'hFFFF);
    peek(0, v); check("R10 setup unused bits zero", v, 16'h83CF);
    peek(2, v); check("R10 compare1 readback", v, 16'd5);
    peek(3, v); check("R10 compare2 readback", v, 16'd10);
    cyc(0, 1, 0, 16'h6000);

    for (int i = 0; i < 20000; i++) begin
      logic [15:0] d;
      logic [1:0] a;
      bit w;
      d = 16'($urandom);
      a = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 7) == 0);
      if (a == 2'd0) begin
        d[15] = ($urandom_range(0, 4) != 0);
        d[3:0] = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(0, 3));
      end else begin
        d = 16'($urandom_range(0, 24));
      end
      cyc($urandom_range(0, 1) == 1, w, a, d);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule